// File: doc/BRIEF.md
# Datapath Self-Test Controller with Pseudorandom Signature

This block sits where converter samples enter a sampled-data digital datapath and can check that datapath without any analog stimulus. In normal operation converter words flow through a configurable formatting stage to the output stream. When software writes the start bit, the controller blocks the converter input. It then feeds words from an internal pseudorandom generator into the same stage for a fixed run of 512 words. Every formatted output word of the run is compressed into a 16-bit signature, and the controller stops by itself.

The output stream stays connected during a run, so the pseudorandom words can be watched as they leave. Both streams use valid/ready. A word moves when valid and ready are high on the same rising edge. The output holds its word and valid until it is taken. The converter input is back-pressured, with s_ready low, whenever the stage cannot accept a word and for the whole of a run. The signature depends on the formatting mode, so one run per mode checks each variant.

Software uses a small register port. Writes are taken on a rising edge while reg_we is high. Reads are combinational from reg_addr. Address 0 is control: bit 0 is start (write-only, reads 0), bit 1 is resume, and bits 3:2 are the format mode. Address 1 is status: bit 0 is busy and bit 1 is done. Addresses 2 and 3 return the low and high bytes of the signature.

Top module: `dp_bist_top`

## Requirements
- R1: After reset, busy and done read 0, both signature bytes read 0 and m_valid is 0.
- R2: While idle, a converter word accepted on an edge appears on m_data with m_valid one cycle later, formatted by mode: 0 passes it unchanged, 1 inverts all 14 bits, 2 inverts bit 13 only, 3 reverses the bit order.
- R3: While m_valid is high and m_ready low, m_valid and m_data hold and s_ready is low. While idle, s_ready equals (not m_valid) or m_ready.
- R4: Writing address 0 with bit 0 set while idle starts a run. From the next cycle busy reads 1, s_ready stays 0 and the output carries formatted pseudorandom words.
- R5: A run injects exactly 512 pseudorandom words. It ends on the edge that takes the 512th of them from the output, after which busy is 0 and done is 1.
- R6: The generator is a 16-bit shift register with next = {s[0]^s[2]^s[3]^s[5], s[15:1]}. The injected word is s[13:0], and the generator advances once per injected word. A start with resume = 0 reloads the seed 0xACE1. A start with resume = 1 continues from the state after the last injected word.
- R7: The signature starts at 0 on each run. For each run word d taken from the output it becomes (sig<<1) ^ (sig[15] ? 0x1021 : 0) ^ d.
- R8: The signature bytes change only when a run completes. A read during a run returns the previous result.
- R9: A start write while busy is ignored. The run ends at the same point with the same signature.
- R10: Done stays set after a run until the next accepted start, which clears it.
- R11: Runs from the same generator state in different format modes give the signatures predicted for each mode, and these differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Converter word valid |
| s_data | input | 14 | Converter word |
| s_ready | output | 1 | Converter word accepted when high with s_valid |
| m_valid | output | 1 | Output word valid |
| m_data | output | 14 | Formatted output word |
| m_ready | input | 1 | Downstream accepts the output word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Write data for the control register |
| reg_rdata | output | 8 | Read data for reg_addr |

## Verification
On every cycle the assertions check several invariants. The output word is held under back-pressure and the converter is blocked while busy. Busy and done are never high together, and the generator never reaches the all-zero state. The signature is frozen during a run, and it is zero on the first cycle of a run. The count of compressed words never passes the count of injected words, nor the run length. Only the bench scenarios can show that the output words of a run follow the pseudorandom sequence, and that the run takes exactly 512 words under random back-pressure. They also show that the final signature matches the model in each mode, that resume and restart pick the right generator state, and that a start written mid-run has no effect.

// File: rtl/dp_bist_pkg.sv
package dp_bist_pkg;
  localparam int SAMPLE_W = 14;
  localparam int LFSR_W   = 16;
  localparam int SIG_W    = 16;
  localparam logic [LFSR_W-1:0] PN_SEED   = 16'hACE1;
  localparam logic [SIG_W-1:0]  MISR_POLY = 16'h1021;

  typedef enum logic [1:0] {
    FMT_PASS = 2'd0,
    FMT_INV  = 2'd1,
    FMT_MSB  = 2'd2,
    FMT_REV  = 2'd3
  } fmt_e;

  function automatic logic [SAMPLE_W-1:0] fmt_apply(fmt_e m, logic [SAMPLE_W-1:0] x);
    logic [SAMPLE_W-1:0] r;
    case (m)
      FMT_INV: r = ~x;
      FMT_MSB: r = x ^ {1'b1, {(SAMPLE_W-1){1'b0}}};
      FMT_REV: for (int i = 0; i < SAMPLE_W; i++) r[i] = x[SAMPLE_W-1-i];
      default: r = x;
    endcase
    return r;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_next(logic [LFSR_W-1:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[LFSR_W-1:1]};
  endfunction

  function automatic logic [SIG_W-1:0] misr_next(logic [SIG_W-1:0] m, logic [SAMPLE_W-1:0] d);
    return {m[SIG_W-2:0], 1'b0} ^ (m[SIG_W-1] ? MISR_POLY : '0) ^ {{(SIG_W-SAMPLE_W){1'b0}}, d};
  endfunction
endpackage

// File: rtl/dp_bist_pn.sv
module dp_bist_pn
  import dp_bist_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = PN_SEED
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                advance,
  output logic [SAMPLE_W-1:0] word
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (restart) state_q <= SEED;
    else if (advance) state_q <= lfsr_next(state_q);
  end

  assign word = state_q[SAMPLE_W-1:0];

  AST_PN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0); // R6
endmodule

// File: rtl/dp_bist_stage.sv
module dp_bist_stage
  import dp_bist_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_tag,
  input  fmt_e                mode,
  output logic                in_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_tag,
  input  logic                out_ready
);
  logic                vld_q, tag_q;
  logic [SAMPLE_W-1:0] dat_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        dat_q <= fmt_apply(mode, in_data);
        tag_q <= in_tag;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_tag   = tag_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R3
endmodule

// File: rtl/dp_bist_misr.sv
module dp_bist_misr
  import dp_bist_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                shift,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SIG_W-1:0]    sig,
  output logic [SIG_W-1:0]    sig_next
);
  logic [SIG_W-1:0] sig_q;

  assign sig_next = misr_next(sig_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig_q <= '0;
    else if (clear) sig_q <= '0;
    else if (shift) sig_q <= sig_next;
  end

  assign sig = sig_q;
endmodule

// File: rtl/dp_bist_top.sv
module dp_bist_top
  import dp_bist_pkg::*;
#(
  parameter int RUN_LEN = 512,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                m_valid,
  output logic [SAMPLE_W-1:0] m_data,
  input  logic                m_ready,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [3:0]          reg_wdata,
  output logic [7:0]          reg_rdata
);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_SIGL = 2'd2, A_SIGH = 2'd3;
  localparam logic [CNT_W-1:0] RUN_END  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

  logic             busy_q, done_q, resume_q;
  fmt_e             mode_q;
  logic [CNT_W-1:0] inj_cnt, chk_cnt;
  logic [SIG_W-1:0] sig_q, misr_sig, misr_nxt;

  logic                ctrl_wr, start_acc, inj_active, pn_adv, chk_fire, run_last;
  logic                st_in_valid, st_in_ready, st_out_tag;
  logic [SAMPLE_W-1:0] st_in_data, pn_word;

  assign ctrl_wr    = reg_we && (reg_addr == A_CTRL);
  assign start_acc  = ctrl_wr && reg_wdata[0] && !busy_q;
  assign inj_active = busy_q && (inj_cnt != RUN_END);
  assign pn_adv     = inj_active && st_in_ready;
  assign chk_fire   = m_valid && m_ready && st_out_tag;
  assign run_last   = chk_fire && (chk_cnt == RUN_LAST);

  assign st_in_valid = busy_q ? inj_active : s_valid;
  assign st_in_data  = busy_q ? pn_word : s_data;
  assign s_ready     = !busy_q && st_in_ready;

  dp_bist_pn u_pn (
    .clk(clk), .rst_n(rst_n),
    .restart(start_acc && !reg_wdata[1]),
    .advance(pn_adv),
    .word(pn_word)
  );

  dp_bist_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(st_in_valid), .in_data(st_in_data), .in_tag(busy_q),
    .mode(mode_q), .in_ready(st_in_ready),
    .out_valid(m_valid), .out_data(m_data), .out_tag(st_out_tag),
    .out_ready(m_ready)
  );

  dp_bist_misr u_misr (
    .clk(clk), .rst_n(rst_n),
    .clear(start_acc), .shift(chk_fire), .din(m_data),
    .sig(misr_sig), .sig_next(misr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= FMT_PASS;
      resume_q <= 1'b0;
    end else if (ctrl_wr) begin
      resume_q <= reg_wdata[1];
      mode_q   <= fmt_e'(reg_wdata[3:2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      inj_cnt <= '0;
      chk_cnt <= '0;
      sig_q   <= '0;
    end else if (start_acc) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      inj_cnt <= '0;
      chk_cnt <= '0;
    end else begin
      if (pn_adv)   inj_cnt <= inj_cnt + 1'b1;
      if (chk_fire) chk_cnt <= chk_cnt + 1'b1;
      if (run_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        sig_q  <= misr_nxt;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'b0, mode_q, resume_q, 1'b0};
      A_STAT:  reg_rdata = {6'b0, done_q, busy_q};
      A_SIGL:  reg_rdata = sig_q[7:0];
      A_SIGH:  reg_rdata = sig_q[15:8];
      default: reg_rdata = '0;
    endcase
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy_q && done_q)); // R10
  AST_CONV_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> !s_ready); // R4
  AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> $stable(sig_q)); // R8
  AST_MISR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) |-> (misr_sig == '0)); // R7
  AST_CHK_LE_INJ: assert property (@(posedge clk) disable iff (!rst_n) chk_cnt <= inj_cnt); // R5
  AST_INJ_BOUND: assert property (@(posedge clk) disable iff (!rst_n) inj_cnt <= RUN_END); // R5
endmodule

// File: tb/dp_bist_top_tb.sv
`timescale 1ns/1ps
module dp_bist_top_tb;
  localparam int RUN = 512;
  logic clk = 0, rst_n = 0;
  logic s_valid = 0, m_ready = 1, reg_we = 0;
  logic [13:0] s_data = 0;
  logic [1:0] reg_addr = 0;
  logic [3:0] reg_wdata = 0;
  logic s_ready, m_valid;
  logic [13:0] m_data;
  logic [7:0] reg_rdata;

  int n_chk = 0, n_fail = 0;
  bit rand_ready = 0, mon_en = 0, finished = 0;
  int beats = 0, mism = 0, mon_mode = 0;
  logic [15:0] exp_pn, bench_pn = 16'hACE1;

  always #4 clk = ~clk;

  dp_bist_top u_dut (.*);

  function automatic logic [15:0] m_pn(logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction
  function automatic logic [13:0] m_fmt(int m, logic [13:0] x);
    logic [13:0] r;
    case (m)
      1: r = ~x;
      2: r = {~x[13], x[12:0]};
      3: for (int i = 0; i < 14; i++) r[i] = x[13-i];
      default: r = x;
    endcase
    return r;
  endfunction
  function automatic logic [15:0] m_sig(logic [15:0] st, int m);
    logic [15:0] g = 0;
    for (int k = 0; k < RUN; k++) begin
      g = {g[14:0], 1'b0} ^ (g[15] ? 16'h1021 : 16'h0) ^ {2'b0, m_fmt(m, st[13:0])};
      st = m_pn(st);
    end
    return g;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask
  task automatic rd_sig(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd2, lo); rd(2'd3, hi); v = {hi, lo};
  endtask
  task automatic wr_ctrl(logic [3:0] d);
    @(negedge clk); reg_addr = 2'd0; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  always @(negedge clk) begin
    if (rand_ready) m_ready = ($urandom % 4) != 0;
    #1;
    if (mon_en && m_valid && m_ready) begin
      if (m_data !== m_fmt(mon_mode, exp_pn[13:0])) mism++;
      exp_pn = m_pn(exp_pn);
      beats++;
    end
  end

  task automatic start_run(int mode, bit resume, output logic [15:0] exp_sig);
    logic [15:0] st;
    rand_ready = 0; m_ready = 1; s_valid = 0;
    repeat (3) @(negedge clk);
    st = resume ? bench_pn : 16'hACE1;
    exp_sig = m_sig(st, mode);
    bench_pn = st;
    for (int k = 0; k < RUN; k++) bench_pn = m_pn(bench_pn);
    exp_pn = st; mon_mode = mode; beats = 0; mism = 0; mon_en = 1;
    rand_ready = 1;
    wr_ctrl({2'(mode), resume, 1'b1});
  endtask

  task automatic wait_run(string req);
    logic [7:0] st;
    int n = 0;
    rd(2'd1, st);
    while (st[0] && n < 20000) begin
      @(negedge clk); rd(2'd1, st); n++;
    end
    repeat (4) @(negedge clk);
    mon_en = 0; rand_ready = 0; m_ready = 1;
    rd(2'd1, st);
    check(st == 8'h02, req, "status after run", st, 2);
    check(beats == RUN, "R5", "run words output", beats, RUN);
    check(mism == 0, "R6", "PN words on output mismatches", mism, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] sg, e1, e2, e3, e4, s1;
    logic [13:0] a, b;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd1, v); check(v == 0, "R1", "status", v, 0);
    rd_sig(sg); check(sg == 0, "R1", "signature", sg, 0);
    check(m_valid == 0, "R1", "m_valid", m_valid, 0);

    // R2 formatting in each mode
    for (int m = 0; m < 4; m++) begin
      wr_ctrl({2'(m), 2'b00});
      for (int j = 0; j < 4; j++) begin
        a = 14'($urandom);
        if (j == 0) a = 14'h0001;
        @(negedge clk); s_valid = 1; s_data = a; #1;
        check(s_ready == 1, "R3", "s_ready idle empty", s_ready, 1);
        @(negedge clk); s_valid = 0; #1;
        check(m_valid && m_data == m_fmt(m, a), "R2", $sformatf("mode %0d word", m), m_data, m_fmt(m, a));
      end
    end

    // R3 back-pressure
    wr_ctrl(4'b0000);
    @(negedge clk); m_ready = 0; a = 14'($urandom); b = 14'($urandom);
    s_valid = 1; s_data = a;
    @(negedge clk); s_data = b; #1;
    check(s_ready == 0, "R3", "s_ready under stall", s_ready, 0);
    repeat (2) @(negedge clk);
    #1; check(m_valid && m_data == a, "R3", "held word", m_data, a);
    m_ready = 1;
    @(negedge clk); s_valid = 0; #1;
    check(m_valid && m_data == b, "R3", "next word after release", m_data, b);
    repeat (2) @(negedge clk);

    // Run 1: mode 0, restart
    start_run(0, 0, e1);
    rd(2'd1, v); check(v == 8'h01, "R4", "busy after start", v, 1);
    s_valid = 1; s_data = 14'h1555; #1;
    check(s_ready == 0, "R4", "converter blocked", s_ready, 0);
    @(negedge clk); s_valid = 0;
    wait_run("R5");
    rd_sig(s1); check(s1 == e1, "R7", "signature mode 0", s1, e1);

    // Run 2: mode 1, resume; mid-run read and ignored start
    start_run(1, 1, e2);
    rd(2'd1, v); check(v == 8'h01, "R10", "done cleared by start", v, 1);
    repeat (10) @(negedge clk);
    rd_sig(sg); check(sg == s1, "R8", "mid-run signature is old", sg, s1);
    wr_ctrl(4'b0111);
    wait_run("R9");
    rd_sig(sg); check(sg == e2, "R9", "signature with ignored start (resume R6)", sg, e2);
    repeat (5) @(negedge clk);
    rd(2'd1, v); check(v == 8'h02, "R10", "done holds", v, 2);

    // Run 3: mode 3, restart
    start_run(3, 0, e3);
    wait_run("R5");
    rd_sig(sg);
    check(sg == e3, "R11", "signature mode 3", sg, e3);
    check(sg != s1, "R11", "mode changes signature", sg, s1);

    // Run 4: mode 0, restart repeats run 1
    start_run(0, 0, e4);
    wait_run("R5");
    rd_sig(sg); check(sg == s1, "R6", "restart repeats signature", sg, s1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule